// File: doc/BRIEF.md
# Opcode Restart and Program-Counter Backup Unit

This unit is the recovery step that runs when an opcode cannot complete: an interrupt is waiting, a trap fires, or a memory fault must be retried. It holds the program counter as two fields, a quadword base (a word address that moves in steps of four words) and a byte position within the 8-byte quadword. A backup moves the saved byte position one byte behind the position the instruction stream currently reports. When that step passes below byte zero, the position wraps to 7 and the base falls by one quadword. The same backup can be requested again by nested faults, and the base still falls only once.

On the interrupt path, which a no-op or a long-running opcode takes when the pending flag is up, the unit backs up the PC, saves the stack pointer and clears the pending flag. It clears it both in its own shadow copy and through a clear pulse to the hardware flag. It then reports one of two decisions: restart the opcode when the wakeup-disable count is nonzero, or enter interrupt service when the count is zero. All effects of one request land on a single clock edge, and completion is flagged on the following cycle.

Top module: `pc_backup_unit`

## Requirements
- R1: After reset, the base and byte position are 0, the shadow pending flag is 0, and done, restart, service and flag-clear outputs are 0.
- R2: A load sets the base and byte position to the load values at the next edge. A load takes priority over any backup or interrupt request in the same cycle, and those requests are then dropped.
- R3: A backup with a current byte position c in 1..7 sets the saved byte position to c-1 and leaves the base unchanged.
- R4: A backup with current position 0, while the saved position is not 7, sets the saved position to 7 and lowers the base by 4 (modulo 2^16).
- R5: A backup with current position 0, while the saved position is already 7 (a repeated backup), leaves the base unchanged and the position at 7.
- R6: An interrupt request while the pending input is high and the wakeup-disable count is nonzero performs one backup. It clears the shadow flag, pulses flag-clear and pulses restart for one cycle, with service low.
- R7: The same request with a wakeup-disable count of zero pulses service for one cycle instead of restart.
- R8: An interrupt request while the pending input is low changes nothing: no done, no decision, no PC change.
- R9: The stack pointer input is captured on every taken interrupt request and presented on the saved-stack output from the next cycle on.
- R10: A backup request and a taken interrupt request in the same cycle produce exactly one backup step and one done pulse.
- R11: done is high for exactly the one cycle after any accepted request.
- R12: The shadow pending flag follows a raised pending input and stays set until an interrupt request clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_i | input | 1 | Load PC fields |
| ld_base_i | input | 16 | Base value to load |
| ld_idx_i | input | 3 | Byte position to load |
| cur_idx_i | input | 3 | Current byte position from the instruction stream |
| bk_req_i | input | 1 | Plain backup request (trap or fault) |
| int_req_i | input | 1 | Interrupt path request (no-op or long opcode) |
| int_pend_i | input | 1 | Hardware interrupt-pending flag |
| wdc_i | input | 8 | Wakeup-disable count |
| sp_i | input | 4 | Current stack pointer |
| base_o | output | 16 | Saved quadword base |
| idx_o | output | 3 | Saved byte position |
| shadow_pend_o | output | 1 | Shadow copy of the pending flag |
| pend_clr_o | output | 1 | One-cycle clear pulse to the hardware flag |
| done_o | output | 1 | Request completed |
| restart_o | output | 1 | Restart the opcode |
| service_o | output | 1 | Enter interrupt service |
| sp_o | output | 4 | Saved stack pointer |

## Verification
The backup rule is driven from a table that pairs saved and current byte positions. The table includes a plain step inside a quadword, a wrap out of byte zero, a wrap with the base at zero, and a repeated backup whose saved position already reads 7. Together these separate a correct once-only borrow from a borrow on every call and from a missing borrow. Directed cases set the wakeup-disable count to zero and to nonzero to tell restart from service. They raise an interrupt request with the flag low to show it is ignored. Simultaneous requests show one step rather than two, and a load in the same cycle as a request shows load priority.

// File: rtl/pcbk_pkg.sv
package pcbk_pkg;
  localparam int BYTE_W = 3;
  typedef logic [BYTE_W-1:0] byte_pos_t;
  localparam byte_pos_t LAST_BYTE = byte_pos_t'((1 << BYTE_W) - 1);
endpackage

// File: rtl/pcbk_step.sv
module pcbk_step
  import pcbk_pkg::*;
#(
  parameter int BASE_W     = 16,
  parameter int QUAD_WORDS = 4
) (
  input  logic [BASE_W-1:0] base_q_i,
  input  byte_pos_t         idx_q_i,
  input  byte_pos_t         cur_i,
  output logic [BASE_W-1:0] base_n_o,
  output byte_pos_t         idx_n_o
);
  localparam logic [BASE_W-1:0] STEP = BASE_W'(QUAD_WORDS);

  logic borrow;

  always_comb begin
    idx_n_o  = cur_i - byte_pos_t'(1);
    // borrow only on the first wrap; a repeat finds the position already last
    borrow   = (cur_i == '0) && (idx_q_i != LAST_BYTE);
    base_n_o = borrow ? (base_q_i - STEP) : base_q_i;
  end
endmodule

// File: rtl/pcbk_decide.sv
module pcbk_decide #(
  parameter int WDC_W = 8
) (
  input  logic             take_i,
  input  logic [WDC_W-1:0] wdc_i,
  output logic             restart_o,
  output logic             service_o
);
  logic wakeups_off;

  always_comb begin
    wakeups_off = |wdc_i;
    restart_o   = take_i & wakeups_off;
    service_o   = take_i & ~wakeups_off;
  end
endmodule

// File: rtl/pc_backup_unit.sv
module pc_backup_unit
  import pcbk_pkg::*;
#(
  parameter int BASE_W     = 16,
  parameter int WDC_W      = 8,
  parameter int SP_W       = 4,
  parameter int QUAD_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [BASE_W-1:0] ld_base_i,
  input  logic [2:0]        ld_idx_i,
  input  logic [2:0]        cur_idx_i,
  input  logic              bk_req_i,
  input  logic              int_req_i,
  input  logic              int_pend_i,
  input  logic [WDC_W-1:0]  wdc_i,
  input  logic [SP_W-1:0]   sp_i,
  output logic [BASE_W-1:0] base_o,
  output logic [2:0]        idx_o,
  output logic              shadow_pend_o,
  output logic              pend_clr_o,
  output logic              done_o,
  output logic              restart_o,
  output logic              service_o,
  output logic [SP_W-1:0]   sp_o
);
  logic [BASE_W-1:0] base_q, base_d, step_base;
  byte_pos_t         idx_q, idx_d, step_idx;
  logic              shadow_q, shadow_d;
  logic [SP_W-1:0]   sp_q, sp_d;
  logic              done_q, done_d;
  logic              rst_q, rst_d, svc_q, svc_d;
  logic              clr_q;
  logic              take_int, do_step;
  logic              en_pc, en_sp;

  assign take_int = int_req_i & int_pend_i & ~ld_i;
  assign do_step  = (bk_req_i | take_int) & ~ld_i;

  pcbk_step #(.BASE_W(BASE_W), .QUAD_WORDS(QUAD_WORDS)) u_step (
    .base_q_i (base_q),
    .idx_q_i  (idx_q),
    .cur_i    (byte_pos_t'(cur_idx_i)),
    .base_n_o (step_base),
    .idx_n_o  (step_idx)
  );

  pcbk_decide #(.WDC_W(WDC_W)) u_decide (
    .take_i    (take_int),
    .wdc_i     (wdc_i),
    .restart_o (rst_d),
    .service_o (svc_d)
  );

  always_comb begin
    en_pc    = ld_i | do_step;
    en_sp    = take_int;
    base_d   = ld_i ? ld_base_i : step_base;
    idx_d    = ld_i ? byte_pos_t'(ld_idx_i) : step_idx;
    sp_d     = sp_i;
    shadow_d = take_int ? 1'b0 : (shadow_q | int_pend_i);
    done_d   = do_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      idx_q    <= '0;
      sp_q     <= '0;
      shadow_q <= 1'b0;
      done_q   <= 1'b0;
      rst_q    <= 1'b0;
      svc_q    <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      if (en_pc) begin
        base_q <= base_d;
        idx_q  <= idx_d;
      end
      if (en_sp) sp_q <= sp_d;
      shadow_q <= shadow_d;
      done_q   <= done_d;
      rst_q    <= rst_d;
      svc_q    <= svc_d;
      clr_q    <= take_int;
    end
  end

  assign base_o        = base_q;
  assign idx_o         = idx_q;
  assign shadow_pend_o = shadow_q;
  assign pend_clr_o    = clr_q;
  assign done_o        = done_q;
  assign restart_o     = rst_q;
  assign service_o     = svc_q;
  assign sp_o          = sp_q;
endmodule

// File: rtl/pc_backup_unit_chk.sv
module pc_backup_unit_chk #(
  parameter int BASE_W = 16,
  parameter int WDC_W  = 8,
  parameter int SP_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_i,
  input logic [BASE_W-1:0] ld_base_i,
  input logic [2:0]        ld_idx_i,
  input logic [2:0]        cur_idx_i,
  input logic              bk_req_i,
  input logic              int_req_i,
  input logic              int_pend_i,
  input logic [WDC_W-1:0]  wdc_i,
  input logic [SP_W-1:0]   sp_i,
  input logic [BASE_W-1:0] base_o,
  input logic [2:0]        idx_o,
  input logic              done_o,
  input logic              restart_o,
  input logic              service_o,
  input logic              pend_clr_o,
  input logic [SP_W-1:0]   sp_o
);
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (base_o == $past(ld_base_i) && idx_o == $past(ld_idx_i)));

  a_r3_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_req_i && !ld_i && cur_idx_i != 3'd0) |=> (idx_o == $past(cur_idx_i) - 3'd1 && $stable(base_o)));

  a_r5_repeat_backup: assert property (@(posedge clk) disable iff (!rst_n)
    ((bk_req_i || int_req_i) && !ld_i && cur_idx_i == 3'd0 && idx_o == 3'd7) |=> $stable(base_o));

  a_r7_one_decision: assert property (@(posedge clk) disable iff (!rst_n)
    !(restart_o && service_o));

  a_r6_clear_with_decision: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr_o |-> $countones({restart_o, service_o}) == 1);

  a_r8_no_pend_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req_i && !int_pend_i && !bk_req_i) |=> (!done_o && !restart_o && !service_o));

  a_r11_done_next: assert property (@(posedge clk) disable iff (!rst_n)
    ((bk_req_i || (int_req_i && int_pend_i)) && !ld_i) |=> done_o);

  a_r9_sp_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req_i && int_pend_i && !ld_i) |=> sp_o == $past(sp_i));
endmodule

bind pc_backup_unit pc_backup_unit_chk #(
  .BASE_W(BASE_W), .WDC_W(WDC_W), .SP_W(SP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .ld_base_i(ld_base_i),
  .ld_idx_i(ld_idx_i), .cur_idx_i(cur_idx_i), .bk_req_i(bk_req_i),
  .int_req_i(int_req_i), .int_pend_i(int_pend_i), .wdc_i(wdc_i),
  .sp_i(sp_i), .base_o(base_o), .idx_o(idx_o), .done_o(done_o),
  .restart_o(restart_o), .service_o(service_o),
  .pend_clr_o(pend_clr_o), .sp_o(sp_o)
);

// File: tb/test_pc_backup_unit.sv
module test_pc_backup_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {load base, load idx, current idx, expected idx, expected base}
  localparam logic [40:0] VEC [NV] = '{
    {16'd100, 3'd5, 3'd5, 3'd4, 16'd100},
    {16'd100, 3'd2, 3'd3, 3'd2, 16'd100},
    {16'd100, 3'd3, 3'd0, 3'd7, 16'd96},
    {16'd100, 3'd7, 3'd0, 3'd7, 16'd100},
    {16'd0,   3'd0, 3'd0, 3'd7, 16'hFFFC},
    {16'd200, 3'd0, 3'd1, 3'd0, 16'd200}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_i = 0, bk_req_i = 0, int_req_i = 0, int_pend_i = 0;
  logic [15:0] ld_base_i = '0;
  logic [2:0] ld_idx_i = '0, cur_idx_i = '0;
  logic [7:0] wdc_i = '0;
  logic [3:0] sp_i = '0;
  logic [15:0] base_o;
  logic [2:0] idx_o;
  logic shadow_pend_o, pend_clr_o, done_o, restart_o, service_o;
  logic [3:0] sp_o;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_backup_unit i_pc_backup_unit (
    .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .ld_base_i(ld_base_i),
    .ld_idx_i(ld_idx_i), .cur_idx_i(cur_idx_i), .bk_req_i(bk_req_i),
    .int_req_i(int_req_i), .int_pend_i(int_pend_i), .wdc_i(wdc_i),
    .sp_i(sp_i), .base_o(base_o), .idx_o(idx_o),
    .shadow_pend_o(shadow_pend_o), .pend_clr_o(pend_clr_o),
    .done_o(done_o), .restart_o(restart_o), .service_o(service_o),
    .sp_o(sp_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] b, input logic [2:0] i);
    @(negedge clk);
    ld_i = 1; ld_base_i = b; ld_idx_i = i;
    @(negedge clk);
    ld_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 base", base_o, 0);
    chk("R1 outs", {idx_o, shadow_pend_o, pend_clr_o, done_o, restart_o, service_o}, 0);
    rst_n = 1;
    load(16'h1234, 3'd6);
    chk("R2 load", {base_o, idx_o}, {16'h1234, 3'd6});

    for (int k = 0; k < NV; k++) begin
      load(VEC[k][40:25], VEC[k][24:22]);
      cur_idx_i = VEC[k][21:19]; bk_req_i = 1;
      @(negedge clk);
      bk_req_i = 0;
      chk("R3/R4/R5 idx", idx_o, VEC[k][18:16]);
      chk("R3/R4/R5 base", base_o, VEC[k][15:0]);
      chk("R11 done", done_o, 1);
      @(negedge clk);
      chk("R11 done drops", done_o, 0);
    end

    // R5: second backup after a wrap keeps the base
    load(16'd40, 3'd2);
    cur_idx_i = 0; bk_req_i = 1;
    @(negedge clk);
    @(negedge clk);
    bk_req_i = 0;
    chk("R5 repeat base", base_o, 16'd36);
    chk("R5 repeat idx", idx_o, 3'd7);

    // R12 shadow follows pending; R6 restart path
    load(16'd80, 3'd4);
    int_pend_i = 1;
    @(negedge clk);
    chk("R12 shadow set", shadow_pend_o, 1);
    wdc_i = 8'd3; sp_i = 4'hA; cur_idx_i = 3'd4; int_req_i = 1;
    @(negedge clk);
    int_req_i = 0; int_pend_i = 0;
    chk("R6 restart", {restart_o, service_o, pend_clr_o, done_o}, 4'b1011);
    chk("R6 shadow clear", shadow_pend_o, 0);
    chk("R6 idx", {base_o, idx_o}, {16'd80, 3'd3});
    chk("R9 sp saved", sp_o, 4'hA);
    @(negedge clk);
    chk("R6 pulse", {restart_o, pend_clr_o, done_o}, 0);

    // R7 service path
    int_pend_i = 1; wdc_i = 0; sp_i = 4'h5; cur_idx_i = 3'd1; int_req_i = 1;
    @(negedge clk);
    int_req_i = 0; int_pend_i = 0;
    chk("R7 service", {restart_o, service_o, pend_clr_o}, 3'b011);
    chk("R9 sp again", sp_o, 4'h5);

    // R8 request without pending
    load(16'd50, 3'd5);
    cur_idx_i = 3'd2; int_req_i = 1; sp_i = 4'h1;
    @(negedge clk);
    int_req_i = 0;
    chk("R8 no effect", {done_o, restart_o, service_o, base_o, idx_o}, {3'b000, 16'd50, 3'd5});
    chk("R8 sp kept", sp_o, 4'h5);

    // R10 both requests: one step only
    load(16'd60, 3'd3);
    int_pend_i = 1; wdc_i = 1; cur_idx_i = 3'd0; bk_req_i = 1; int_req_i = 1;
    @(negedge clk);
    bk_req_i = 0; int_req_i = 0; int_pend_i = 0;
    chk("R10 one step", {base_o, idx_o}, {16'd56, 3'd7});
    chk("R10 done", {done_o, restart_o}, 2'b11);
    @(negedge clk);
    chk("R10 single pulse", done_o, 0);

    // R2 load priority over requests
    @(negedge clk);
    ld_i = 1; ld_base_i = 16'd9; ld_idx_i = 3'd1; bk_req_i = 1; cur_idx_i = 3'd0;
    @(negedge clk);
    ld_i = 0; bk_req_i = 0;
    chk("R2 priority", {base_o, idx_o, done_o}, {16'd9, 3'd1, 1'b0});

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule